// File: doc/BRIEF.md
# UART Status Flags and Interrupt Request

This block keeps the status flags of a UART peripheral and merges them into one interrupt request line. A receiver stub delivers each incoming byte as a one-cycle strobe, together with a parity-error and a framing-error indication. A transmit-shifter stub pulses a strobe when it takes the pending byte. Software reaches the block through a small register port with three registers: data, status and control.

Flags are cleared as a side effect of register traffic. A data read drains the receive flag, and a data write fills the transmit holding byte. Each source has its own enable bit in the control register. Clearing an enable removes only that source from the shared request. The request is the registered OR of all enabled flags.

Register map: address 0 is data, address 1 is status, address 2 is control, and address 3 reads zero and ignores writes. Status bits are bit0 receive-not-empty (rx_full), bit1 transmit-empty (tx_empty), bit2 parity error, bit3 framing error and bit4 overrun. Control bits are bit0 receive enable, bit1 transmit enable, bit2 parity enable and bit3 error enable. The error enable covers both framing and overrun.

Top module: `uart_irq_flags`

## Requirements
- R1: After reset, status reads 0x02 (only tx_empty set), control reads 0x00 and irq_o is 0.
- R2: A cycle with rx_valid_i high sets status bit0, and a following read of address 0 returns the received byte.
- R3: rx_full clears after a read strobe on address 0. It also clears after a status write with bit0 = 0. A status write with bit0 = 1 leaves it set.
- R4: irq_o is registered. It rises one cycle after an enabled flag becomes set, and it falls one cycle after the last enabled flag or enable goes away.
- R5: With control bit0 = 0, a set rx_full does not raise irq_o, while an enabled tx_empty still does.
- R6: With tx_empty set and control bit1 = 1, irq_o stays high until a data write or a clear of control bit1. A data write clears tx_empty and drives the byte on tx_data_o. A tx_ready_i strobe sets tx_empty again.
- R7: A received byte flagged with a parity error sets status bit2, which raises irq_o only when control bit2 = 1.
- R8: A received byte flagged with a framing error sets status bit3, which raises irq_o only when control bit3 = 1.
- R9: A byte arriving while rx_full is set and not being read in that cycle replaces the held byte and sets status bit4. Control bit3 enables bit4 onto irq_o.
- R10: A status write with 1 in bit2, bit3 or bit4 clears that error flag. A 0 in those bits leaves them unchanged.
- R11: The control register reads back the value written to address 2, in its low four bits.
- R12: A byte arriving in the same cycle as a data read keeps rx_full set, holds the new byte and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte-received strobe from the receiver stub |
| rx_data_i | input | DATA_W | Received byte |
| rx_par_err_i | input | 1 | Parity error on the strobed byte |
| rx_frm_err_i | input | 1 | Framing error on the strobed byte |
| tx_ready_i | input | 1 | Shifter has taken the pending byte |
| tx_data_o | output | DATA_W | Byte held for the shifter |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (side effects on address 0) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational on the address |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The assertions assume that each bus cycle carries at most one of bus_rd_i or bus_wr_i. They also assume that tx_ready_i never arrives in the same cycle as a data write. Under these assumptions the receive, transmit and overrun rules hold as stated for every cycle. The bench drives each strobe for exactly one cycle and uses only one bus operation at a time. It issues tx_ready_i only after a data write has emptied the holding byte. It deliberately places a received byte in the same cycle as a data read to exercise the set-wins ordering.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  // status bit positions, also source index on the request merge
  localparam int S_RXNE = 0;
  localparam int S_TXE  = 1;
  localparam int S_PAR  = 2;
  localparam int S_FRM  = 3;
  localparam int S_OVR  = 4;
  localparam int N_SRC  = 5;
  // control bit positions
  localparam int C_RX   = 0;
  localparam int C_TX   = 1;
  localparam int C_PAR  = 2;
  localparam int C_ERR  = 3;
  localparam int N_CTRL = 4;
endpackage

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              data_rd_i,
  input  logic              rxne_wr0_i,
  input  logic              par_clr_i,
  input  logic              frm_clr_i,
  input  logic              ovr_clr_i,
  output logic              rxne_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] rx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxne_o    <= 1'b0;
      rx_data_o <= '0;
    end else if (rx_valid_i) begin
      rxne_o    <= 1'b1;
      rx_data_o <= rx_data_i;
    end else if (data_rd_i || rxne_wr0_i) begin
      rxne_o    <= 1'b0;
    end
  end

  // error flags: set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o <= 1'b0;
      frm_o <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      if (rx_valid_i && rx_par_err_i) par_o <= 1'b1;
      else if (par_clr_i)             par_o <= 1'b0;
      if (rx_valid_i && rx_frm_err_i) frm_o <= 1'b1;
      else if (frm_clr_i)             frm_o <= 1'b0;
      // a byte consumed in the same cycle is not lost
      if (rx_valid_i && rxne_o && !data_rd_i) ovr_o <= 1'b1;
      else if (ovr_clr_i)                     ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_ready_i,
  output logic              txe_o,
  output logic [DATA_W-1:0] tx_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_o     <= 1'b1;
      tx_data_o <= '0;
    end else if (data_wr_i) begin
      txe_o     <= 1'b0;
      tx_data_o <= wdata_i;
    end else if (tx_ready_i) begin
      txe_o     <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = src_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |gated;
  end
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int PAD_S = DATA_W - N_SRC;
  localparam int PAD_C = DATA_W - N_CTRL;

  logic              data_rd, data_wr, stat_wr, ctrl_wr;
  logic              rxne, txe, par_f, frm_f, ovr_f;
  logic [DATA_W-1:0] rx_q;
  logic [N_CTRL-1:0] ctrl_q;
  logic [N_SRC-1:0]  stat_v, en_v;

  assign data_rd = bus_rd_i && (bus_addr_i == A_DATA);
  assign data_wr = bus_wr_i && (bus_addr_i == A_DATA);
  assign stat_wr = bus_wr_i && (bus_addr_i == A_STAT);
  assign ctrl_wr = bus_wr_i && (bus_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata_i[N_CTRL-1:0];
  end

  uart_rx_status #(.DATA_W(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_par_err_i (rx_par_err_i),
    .rx_frm_err_i (rx_frm_err_i),
    .data_rd_i    (data_rd),
    .rxne_wr0_i   (stat_wr && !bus_wdata_i[S_RXNE]),
    .par_clr_i    (stat_wr && bus_wdata_i[S_PAR]),
    .frm_clr_i    (stat_wr && bus_wdata_i[S_FRM]),
    .ovr_clr_i    (stat_wr && bus_wdata_i[S_OVR]),
    .rxne_o       (rxne),
    .par_o        (par_f),
    .frm_o        (frm_f),
    .ovr_o        (ovr_f),
    .rx_data_o    (rx_q)
  );

  uart_tx_status #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .wdata_i    (bus_wdata_i),
    .tx_ready_i (tx_ready_i),
    .txe_o      (txe),
    .tx_data_o  (tx_data_o)
  );

  always_comb begin
    stat_v         = '0;
    stat_v[S_RXNE] = rxne;
    stat_v[S_TXE]  = txe;
    stat_v[S_PAR]  = par_f;
    stat_v[S_FRM]  = frm_f;
    stat_v[S_OVR]  = ovr_f;
    en_v           = '0;
    en_v[S_RXNE]   = ctrl_q[C_RX];
    en_v[S_TXE]    = ctrl_q[C_TX];
    en_v[S_PAR]    = ctrl_q[C_PAR];
    en_v[S_FRM]    = ctrl_q[C_ERR];
    en_v[S_OVR]    = ctrl_q[C_ERR];
  end

  uart_irq_merge #(.N(N_SRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (stat_v),
    .en_i   (en_v),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_DATA:  bus_rdata_o = rx_q;
      A_STAT:  bus_rdata_o = {{PAD_S{1'b0}}, stat_v};
      A_CTRL:  bus_rdata_o = {{PAD_C{1'b0}}, ctrl_q};
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_flags_chk.sv
module uart_irq_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic       bus_rd_i,
  input logic       bus_wr_i,
  input logic [1:0] bus_addr_i,
  input logic       rxne,
  input logic       txe,
  input logic       ovr_f,
  input logic [3:0] ctrl_q,
  input logic       irq_o
);
  // R2
  rx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rxne);
  // R3
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == 2'd0 && !rx_valid_i) |=> !rxne);
  // R9
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rxne && !(bus_rd_i && bus_addr_i == 2'd0)) |=> ovr_f);
  // R4
  rx_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxne && ctrl_q[0]) |=> irq_o);
  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txe && ctrl_q[1]) |=> irq_o);
  // R6
  tx_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'd0) |=> !txe);
  // R1
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == 4'd0) |=> !irq_o);
endmodule

bind uart_irq_flags uart_irq_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .bus_rd_i   (bus_rd_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .rxne       (rxne),
  .txe        (txe),
  .ovr_f      (ovr_f),
  .ctrl_q     (ctrl_q),
  .irq_o      (irq_o)
);

// File: tb/uart_irq_flags_tb_top.sv
module uart_irq_flags_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_par_err_i = 1'b0;
  logic       rx_frm_err_i = 1'b0;
  logic       tx_ready_i = 1'b0;
  logic [7:0] tx_data_o;
  logic [1:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  uart_irq_flags dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #2 d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic rx(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d; rx_par_err_i = pe; rx_frm_err_i = fe;
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_par_err_i = 1'b0; rx_frm_err_i = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk_i);
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(2'd1, v); chk("R1 status", v, 8'h02);
    peek(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h0A);
    peek(2'd2, v); chk("R11 ctrl readback", v, 8'h0A);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_rx_basic();
    logic [7:0] v;
    wr(2'd2, 8'h01);
    rx(8'hA5, 1'b0, 1'b0);
    peek(2'd1, v); chk("R2 rx_full set", v, 8'h03);
    chk("R4 irq one cycle late", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    chk("R4 irq rises", {7'd0, irq_o}, 8'h01);
    rd(2'd0, v); chk("R2 data", v, 8'hA5);
    peek(2'd1, v); chk("R3 read clears", v, 8'h02);
    chk("R4 irq still high", {7'd0, irq_o}, 8'h01);
    @(negedge clk_i);
    chk("R4 irq falls", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_rx_wr0();
    logic [7:0] v;
    rx(8'h5A, 1'b0, 1'b0);
    wr(2'd1, 8'h01);
    peek(2'd1, v); chk("R3 write 1 keeps", v, 8'h03);
    wr(2'd1, 8'h00);
    peek(2'd1, v); chk("R3 write 0 clears", v, 8'h02);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(2'd0, 8'h77);
    wr(2'd2, 8'h02);
    rx(8'h12, 1'b0, 1'b0);
    @(negedge clk_i); @(negedge clk_i);
    peek(2'd1, v); chk("R5 rx_full only", v, 8'h01);
    chk("R5 rx masked", {7'd0, irq_o}, 8'h00);
    tx_take();
    @(negedge clk_i);
    chk("R5 tx still raises", {7'd0, irq_o}, 8'h01);
    rd(2'd0, v);
    wr(2'd2, 8'h00);
    @(negedge clk_i);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr(2'd2, 8'h02);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R6 irq held", {7'd0, irq_o}, 8'h01);
    end
    wr(2'd0, 8'h3C);
    chk("R6 tx_data", tx_data_o, 8'h3C);
    peek(2'd1, v); chk("R6 tx_empty clear", v, 8'h00);
    @(negedge clk_i);
    chk("R6 irq drops on write", {7'd0, irq_o}, 8'h00);
    tx_take();
    peek(2'd1, v); chk("R6 tx_empty again", v, 8'h02);
    @(negedge clk_i);
    chk("R6 irq back", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h00);
    @(negedge clk_i);
    chk("R6 irq drops on disable", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_err();
    logic [7:0] v;
    wr(2'd2, 8'h04);
    rx(8'h01, 1'b0, 1'b1);
    @(negedge clk_i); @(negedge clk_i);
    peek(2'd1, v); chk("R8 frame flag", v, 8'h0B);
    chk("R8 frame masked", {7'd0, irq_o}, 8'h00);
    rx(8'h02, 1'b1, 1'b0);
    @(negedge clk_i);
    peek(2'd1, v); chk("R7 parity flag", v, 8'h1F);
    chk("R7 parity irq", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h05);
    @(negedge clk_i);
    peek(2'd1, v); chk("R10 w1c parity", v, 8'h1B);
    chk("R7 irq gone", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h08);
    @(negedge clk_i);
    chk("R8 error enable", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h09);
    peek(2'd1, v); chk("R10 w1c frame", v, 8'h13);
    @(negedge clk_i);
    chk("R9 overrun irq", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h11);
    @(negedge clk_i);
    peek(2'd1, v); chk("R10 w1c overrun", v, 8'h03);
    chk("R10 irq off", {7'd0, irq_o}, 8'h00);
    rd(2'd0, v);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ovr();
    logic [7:0] v;
    rx(8'h11, 1'b0, 1'b0);
    rx(8'h22, 1'b0, 1'b0);
    peek(2'd1, v); chk("R9 overrun flag", v, 8'h13);
    peek(2'd0, v); chk("R9 overwrite", v, 8'h22);
    wr(2'd1, 8'h11);
    rd(2'd0, v);
  endtask

  task automatic t_same();
    logic [7:0] v;
    rx(8'h33, 1'b0, 1'b0);
    @(negedge clk_i);
    bus_addr_i = 2'd0; bus_rd_i = 1'b1;
    rx_valid_i = 1'b1; rx_data_i = 8'h44;
    #2 v = bus_rdata_o; chk("R12 old byte read", v, 8'h33);
    @(negedge clk_i);
    bus_rd_i = 1'b0; rx_valid_i = 1'b0;
    peek(2'd1, v); chk("R12 rx_full kept no overrun", v, 8'h03);
    peek(2'd0, v); chk("R12 new byte", v, 8'h44);
  endtask

  initial begin
    #45 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rx_basic();
    t_rx_wr0();
    t_mask();
    t_tx();
    t_err();
    t_ovr();
    t_same();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule